// File: doc/BRIEF.md
# Two-Wire Bus SCL Waveform Generator

This block produces the serial clock for a two-wire bus master. It counts system clocks to time each low and high half of the SCL waveform. A single configuration word gives three things: a divider for the low half, a divider for the high half, and a power-of-two exponent that both halves share. Each half lasts `divider * 2^exponent + OFFSET` system clocks. `OFFSET` is a fixed implementation constant, typically 3 or 4. When the two dividers are equal, the bus clock is `Fsys / (2 * (div * 2^exp + OFFSET))`. For example, the settings for 100 kHz or 400 kHz from a given system clock are chosen by the software that drives the block.

The transfer engine holds `enable` high while it needs the bus clock. When `enable` is low, SCL rests high and all timing state is cleared. Raising `enable` starts a low half at once. Every SCL edge is marked by a one-cycle `phase_start_o` pulse, which the engine uses to place data changes and samples. The configuration word is read only at a half boundary. Changing it part-way through a half therefore never shortens or stretches the half already running.

Top module: `scl_wavegen`

## Requirements
- R1: While reset is asserted, and afterwards while `enable` is low, `scl_o` is 1 and `phase_start_o` is 0.
- R2: In the cycle after the first clock edge that samples `enable` high from idle, `scl_o` is 0 and `phase_start_o` is 1. That low half lasts `low_div * 2^exp + OFFSET` cycles, which gives exactly `OFFSET` cycles when the divider is 0.
- R3: A high half lasts `high_div * 2^exp + OFFSET` cycles, and the halves alternate low and high.
- R4: An exponent field above `EXP_MAX` is treated as `EXP_MAX`. With the defaults (`EXP_MAX`=5), the values 6 and 7 both scale by 32.
- R5: Configuration word layout: bits 7:0 hold the low divider, bits 15:8 the high divider, and bits 18:16 the exponent.
- R6: The configuration is sampled at the clock edge that starts a half, and it governs only that half. A change made during a half leaves the length of that half unchanged.
- R7: `phase_start_o` is 1 exactly in the first cycle of each half, which is the cycle in which `scl_o` has just changed. In every other cycle it is 0.
- R8: If `enable` is sampled low in the middle of a half, then in the next cycle `scl_o` is 1 and `phase_start_o` is 0. The next enable begins a full-length low half.
- R9: With equal dividers, one SCL period lasts `2 * (div * 2^exp + OFFSET)` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request from the transfer engine; low holds SCL high |
| cfg_word | input | 2*DIV_W+EXP_W (19) | Low divider, high divider and exponent |
| scl_o | output | 1 | Generated SCL level |
| phase_start_o | output | 1 | One-cycle pulse in the first cycle of each half |

## Verification
The checker assumes that `enable` and `cfg_word` are synchronous to `clk` and settle between edges. It also assumes that the offset parameter is at least 1, so no half can be shorter than `OFFSET` cycles. The bench drives every input on the falling edge and compares outputs on the next falling edge, which keeps it within these assumptions. Configuration changes are placed both on half boundaries and in the middle of halves. `enable` is also dropped part-way through a low half, so both the sampling point and the abort path are exercised.

// File: rtl/scl_wg_pkg.sv
package scl_wg_pkg;
   // Level of the half currently being timed
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } scl_lvl_e;

   // Longest half, in system clocks, for a given field geometry
   function automatic int unsigned max_half_len(int unsigned div_w,
                                                int unsigned exp_max,
                                                int unsigned offset);
      return ((2 ** div_w) - 1) * (2 ** exp_max) + offset;
   endfunction
endpackage

// File: rtl/scl_wg_field_dec.sv
module scl_wg_field_dec #(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned EXP_W   = 3,
   parameter int unsigned EXP_MAX = 5,
   localparam int unsigned CFG_W  = 2 * DIV_W + EXP_W,
   localparam int unsigned EXP_SW = $clog2(EXP_MAX + 1)
) (
   input  logic [CFG_W-1:0]  cfg_word,
   input  logic              next_high,
   output logic [DIV_W-1:0]  div_o,
   output logic [EXP_SW-1:0] exp_o
);
   logic [DIV_W-1:0] lo_div;
   logic [DIV_W-1:0] hi_div;
   logic [EXP_W-1:0] exp_raw;

   assign lo_div  = cfg_word[DIV_W-1:0];
   assign hi_div  = cfg_word[2*DIV_W-1:DIV_W];
   assign exp_raw = cfg_word[CFG_W-1:2*DIV_W];

   assign div_o = next_high ? hi_div : lo_div;

   generate
      if (EXP_MAX >= (2 ** EXP_W) - 1) begin : g_no_cap
         // Field cannot exceed the limit: pass it straight through
         assign exp_o = EXP_SW'(exp_raw);
      end else begin : g_cap
         localparam logic [EXP_W-1:0]  CAP_W = EXP_W'(EXP_MAX);
         localparam logic [EXP_SW-1:0] CAP_S = EXP_SW'(EXP_MAX);
         assign exp_o = (exp_raw > CAP_W) ? CAP_S : exp_raw[EXP_SW-1:0];
      end
   endgenerate
endmodule

// File: rtl/scl_wg_len_calc.sv
module scl_wg_len_calc #(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned EXP_SW  = 3,
   parameter int unsigned OFFSET  = 3,
   parameter int unsigned CNT_W   = 13
) (
   input  logic [DIV_W-1:0]  div_i,
   input  logic [EXP_SW-1:0] exp_i,
   output logic [CNT_W-1:0]  len_m1
);
   // Logarithmic shifter: stage k shifts by 2^k when exponent bit k is set
   logic [CNT_W-1:0] stage [0:EXP_SW];

   assign stage[0] = {{(CNT_W-DIV_W){1'b0}}, div_i};

   generate
      for (genvar k = 0; k < EXP_SW; k++) begin : g_shift
         assign stage[k+1] = exp_i[k] ? (stage[k] << (2 ** k)) : stage[k];
      end
   endgenerate

   localparam logic [CNT_W-1:0] OFS_M1 = CNT_W'(OFFSET - 1);

   assign len_m1 = stage[EXP_SW] + OFS_M1;
endmodule

// File: rtl/scl_wg_phase_ctr.sv
module scl_wg_phase_ctr
   import scl_wg_pkg::*;
#(
   parameter int unsigned CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] len_m1,
   output logic             next_high,
   output logic             scl_o,
   output logic             phase_start_o
);
   logic             running_q;
   scl_lvl_e         lvl_q;
   logic [CNT_W-1:0] remain_q;
   logic             pulse_q;

   // Running and currently low: the half to be loaded next is high
   assign next_high = running_q && (lvl_q == LVL_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         lvl_q     <= LVL_HIGH;
         remain_q  <= '0;
         pulse_q   <= 1'b0;
      end else if (!enable) begin
         running_q <= 1'b0;
         lvl_q     <= LVL_HIGH;
         remain_q  <= '0;
         pulse_q   <= 1'b0;
      end else if (!running_q) begin
         running_q <= 1'b1;
         lvl_q     <= LVL_LOW;
         remain_q  <= len_m1;
         pulse_q   <= 1'b1;
      end else if (remain_q == '0) begin
         lvl_q     <= (lvl_q == LVL_LOW) ? LVL_HIGH : LVL_LOW;
         remain_q  <= len_m1;
         pulse_q   <= 1'b1;
      end else begin
         remain_q  <= remain_q - 1'b1;
         pulse_q   <= 1'b0;
      end
   end

   assign scl_o         = (lvl_q == LVL_HIGH);
   assign phase_start_o = pulse_q;
endmodule

// File: rtl/scl_wavegen.sv
module scl_wavegen
   import scl_wg_pkg::*;
#(
   parameter int unsigned DIV_W   = 8,
   parameter int unsigned EXP_W   = 3,
   parameter int unsigned EXP_MAX = 5,
   parameter int unsigned OFFSET  = 3,
   localparam int unsigned CFG_W   = 2 * DIV_W + EXP_W,
   localparam int unsigned EXP_SW  = $clog2(EXP_MAX + 1),
   localparam int unsigned MAX_LEN = max_half_len(DIV_W, EXP_MAX, OFFSET),
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CFG_W-1:0] cfg_word,
   output logic             scl_o,
   output logic             phase_start_o
);
   // Elaboration-time parameter checks
   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
      if (EXP_MAX < 1) begin : g_bad_exp
         $error("EXP_MAX must be at least 1");
      end
      if (OFFSET < 1) begin : g_bad_ofs
         $error("OFFSET must be at least 1");
      end
      if (EXP_SW > EXP_W) begin : g_bad_field
         $error("EXP_W too narrow to hold EXP_MAX");
      end
   endgenerate

   logic              nxt_high;
   logic [DIV_W-1:0]  sel_div;
   logic [EXP_SW-1:0] sel_exp;
   logic [CNT_W-1:0]  half_m1;

   scl_wg_field_dec #(
      .DIV_W   (DIV_W),
      .EXP_W   (EXP_W),
      .EXP_MAX (EXP_MAX)
   ) u_dec (
      .cfg_word  (cfg_word),
      .next_high (nxt_high),
      .div_o     (sel_div),
      .exp_o     (sel_exp)
   );

   scl_wg_len_calc #(
      .DIV_W  (DIV_W),
      .EXP_SW (EXP_SW),
      .OFFSET (OFFSET),
      .CNT_W  (CNT_W)
   ) u_len (
      .div_i  (sel_div),
      .exp_i  (sel_exp),
      .len_m1 (half_m1)
   );

   scl_wg_phase_ctr #(
      .CNT_W (CNT_W)
   ) u_ctr (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .len_m1        (half_m1),
      .next_high     (nxt_high),
      .scl_o         (scl_o),
      .phase_start_o (phase_start_o)
   );
endmodule

// File: rtl/scl_wg_chk.sv
module scl_wg_chk #(
   parameter int unsigned OFFSET  = 3,
   parameter int unsigned MAX_LEN = 8163,
   localparam int unsigned GAP_W  = $clog2(MAX_LEN + 2) + 1
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_o,
   input logic phase_start_o
);
   localparam logic [GAP_W-1:0] MIN_G = GAP_W'(OFFSET);
   localparam logic [GAP_W-1:0] MAX_G = GAP_W'(MAX_LEN);

   // Cycles since the last observed half start
   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (!enable) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (phase_start_o) begin
         gap_q  <= GAP_W'(1);
         seen_q <= 1'b1;
      end else if (gap_q != '1) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (scl_o && !phase_start_o)); // R8

   AST_PULSE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_start_o |-> (scl_o != $past(scl_o))); // R7

   AST_EDGE_HAS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && (scl_o != $past(scl_o))) |-> phase_start_o); // R7

   AST_MIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_start_o && seen_q && enable) |-> (gap_q >= MIN_G)); // R2

   AST_MAX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && enable) |-> (gap_q <= MAX_G)); // R4
endmodule

bind scl_wavegen scl_wg_chk #(
   .OFFSET  (OFFSET),
   .MAX_LEN (MAX_LEN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .scl_o         (scl_o),
   .phase_start_o (phase_start_o)
);

// File: tb/scl_wavegen_tb.sv
`timescale 1ns/1ps
module scl_wavegen_tb;
   localparam int EMAX = 5;
   localparam int OFS  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [18:0] cfg = '0;
   logic        scl;
   logic        ps;

   int    n_chk = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #4 clk = ~clk;

   scl_wavegen #(.DIV_W(8), .EXP_W(3), .EXP_MAX(EMAX), .OFFSET(OFS)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(en), .cfg_word(cfg),
      .scl_o(scl), .phase_start_o(ps)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // R5 layout: exponent 18:16, high divider 15:8, low divider 7:0
   function automatic logic [18:0] mk(int lo, int hi, int ex);
      return {3'(ex), 8'(hi), 8'(lo)};
   endfunction

   function automatic int half(int dv, int ex);
      int e;
      e = (ex > EMAX) ? EMAX : ex;
      return dv * (1 << e) + OFS;
   endfunction

   // Behavioural reference: remaining cycles of the current half
   int m_scl = 1, m_ps = 0, m_run = 0, m_rem = 0;
   always @(posedge clk) begin
      if (!rst_n || !en) begin
         m_scl = 1; m_ps = 0; m_run = 0; m_rem = 0;
      end else if (m_run == 0) begin
         m_run = 1; m_scl = 0; m_ps = 1;
         m_rem = half(int'(cfg[7:0]), int'(cfg[18:16]));
      end else if (m_rem == 1) begin
         m_scl = 1 - m_scl; m_ps = 1;
         m_rem = half(m_scl ? int'(cfg[15:8]) : int'(cfg[7:0]), int'(cfg[18:16]));
      end else begin
         m_rem--; m_ps = 0;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         chk({cur_req, " model scl"}, int'(scl), m_scl);
         chk({cur_req, " model pulse R7"}, int'(ps), m_ps);
      end
   end

   // Called in the first cycle of a half; returns its length and level
   task automatic phase_len(output int n, output int lvl,
                            input bit chg = 1'b0, input logic [18:0] nc = '0);
      lvl = int'(scl);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (chg && n == 3) cfg = nc;
      end while (!ps);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      chk("WATCHDOG", 0, 1);
      finish_run();
   end

   initial begin
      int n, lv, n2, lv2;
      repeat (3) @(negedge clk);
      chk("R1 reset scl", int'(scl), 1);
      chk("R1 reset pulse", int'(ps), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 idle scl", int'(scl), 1);

      // R2/R3: low 2, high 5, exp 1 -> 7 and 13
      cur_req = "R2";
      cfg = mk(2, 5, 1);
      en = 1'b1;
      @(negedge clk);
      chk("R2 first scl", int'(scl), 0);
      chk("R2 first pulse", int'(ps), 1);
      phase_len(n, lv);
      chk("R2 low len", n, 7);
      chk("R3 level after low", int'(scl), 1);
      cur_req = "R3";
      phase_len(n, lv);
      chk("R3 high len", n, 13);
      chk("R3 level after high", int'(scl), 0);

      // R6: change at the start of a low half; the running half keeps old value
      cur_req = "R6";
      cfg = mk(4, 3, 2);
      phase_len(n, lv);
      chk("R6 running low keeps len", n, 7);
      cur_req = "R5";
      phase_len(n, lv);
      chk("R5 high field len", n, 15);
      phase_len(n, lv);
      chk("R5 low field len", n, 19);

      // R6: mid-half change during a high half
      cur_req = "R6";
      phase_len(n, lv, 1'b1, mk(0, 2, 2));
      chk("R6 mid change level", lv, 1);
      chk("R6 mid change len", n, 15);
      phase_len(n, lv);
      chk("R2 zero divider len", n, OFS);
      phase_len(n, lv);
      chk("R6 new high len", n, 11);

      // R4: exponent saturation
      cur_req = "R4";
      cfg = mk(2, 1, 6);
      phase_len(n, lv);
      phase_len(n, lv);
      chk("R4 exp 6 capped", n, (lv == 1) ? half(1, 5) : half(2, 5));
      cfg = mk(1, 1, 7);
      phase_len(n, lv);
      phase_len(n, lv);
      chk("R4 exp 7 capped", n, 35);

      // R9: equal dividers give period 2*(div*2^exp+OFS)
      cur_req = "R9";
      cfg = mk(3, 3, 2);
      phase_len(n, lv);
      phase_len(n, lv);
      phase_len(n2, lv2);
      chk("R9 period", n + n2, 30);

      // R8: abort in the middle of a half, then restart
      cur_req = "R8";
      if (scl != 1'b0) phase_len(n, lv);
      repeat (4) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R8 abort scl", int'(scl), 1);
      chk("R8 abort pulse", int'(ps), 0);
      cfg = mk(3, 3, 0);
      repeat (3) @(negedge clk);
      chk("R8 held idle", int'(scl), 1);
      en = 1'b1;
      @(negedge clk);
      chk("R8 restart low", int'(scl), 0);
      phase_len(n, lv);
      chk("R8 full low after restart", n, 6);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule